// File: doc/BRIEF.md
# User-Gated Stream Word Receiver

This block is the receiving end of an AXI-Stream link that carries single 32-bit beats. It lets a downstream user decide when words may flow: the user raises its own ready input whenever it can take a word, and the block answers by raising the stream tready signal toward the transmitter. A word changes hands only on a clock edge at which tvalid and tready are both high.

Each accepted word is copied into a held output register together with its tlast flag. A one-cycle done pulse tells the user that a new word has arrived. The user reads the data register at that pulse or at any later time before the next transfer.

A parameter chooses how tready is formed. The default registers the user's ready signal, which gives one cycle of latency in both directions. The other option passes it through combinationally, gated by reset. All requirements below describe the default, registered variant.

Top module: `strm_rx_gate`

## Requirements
- R1: While rst_n is low, s_tready, usr_done, usr_last and every bit of usr_data are 0.
- R2: s_tready equals the value usr_ready had at the previous rising clock edge. It rises one cycle after usr_ready rises and falls one cycle after usr_ready falls.
- R3: A word is accepted only at a rising edge where both s_tvalid and s_tready are 1. When s_tready is 0, s_tvalid has no effect, usr_done stays 0 and usr_data keeps its value.
- R4: After an accepting edge, usr_data shows the s_tdata that was presented at that edge.
- R5: usr_data and usr_last hold the last accepted word and flag until the next accepting edge, whatever s_tdata and s_tlast do in between.
- R6: usr_done is 1 for exactly the one cycle after each accepting edge and 0 otherwise. Back-to-back accepted beats keep it high on consecutive cycles, each cycle with the new word.
- R7: usr_last shows the s_tlast of the accepted beat. A beat with s_tlast equal to 0 is still accepted and delivered.
- R8: When usr_ready falls while s_tvalid is high, the beat present at the next edge is still accepted, because s_tready is still 1 there. From the following edge on, no beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tvalid | input | 1 | Stream valid from the transmitter |
| s_tdata | input | DATA_W (32) | Stream data word |
| s_tlast | input | 1 | Stream last flag |
| s_tready | output | 1 | Stream ready toward the transmitter |
| usr_ready | input | 1 | User can take a word |
| usr_data | output | DATA_W (32) | Last accepted word, held |
| usr_last | output | 1 | tlast of the last accepted word, held |
| usr_done | output | 1 | One-cycle pulse per accepted word |

## Verification
The assertions assume the transmitter and the user drive known 0/1 levels once reset is released. They do not require the transmitter to hold tvalid or tdata stable while it is stalled, so they check only what the receiver itself guarantees. The stimulus changes every input only on falling clock edges and never leaves an input undriven, so each rising edge sees settled values. Stall and withdrawal cases are built as explicit directed sequences.

// File: rtl/strm_rx_pkg.sv
package strm_rx_pkg;
   // How the stream ready output is derived from the user's ready input
   typedef enum logic {
      RDY_COMB = 1'b0,   // combinational pass-through, gated by reset
      RDY_REG  = 1'b1    // registered, one cycle of latency
   } rdy_mode_e;

   localparam int unsigned DEF_DATA_W = 32;
endpackage

// File: rtl/strm_rx_rdy.sv
module strm_rx_rdy #(
   parameter strm_rx_pkg::rdy_mode_e RDY_MODE = strm_rx_pkg::RDY_REG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic usr_ready,
   output logic s_tready
);

   generate
      if (RDY_MODE == strm_rx_pkg::RDY_REG) begin : g_reg
         logic rdy_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rdy_q <= 1'b0;
            else        rdy_q <= usr_ready;
         end
         assign s_tready = rdy_q;

         AST_RDY_LAGS_USER: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (s_tready == $past(usr_ready))); // R2
         AST_RDY_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !s_tready); // R1
      end else begin : g_comb
         assign s_tready = usr_ready & rst_n;
      end
   endgenerate

endmodule

// File: rtl/strm_rx_cap.sv
module strm_rx_cap #(
   parameter int unsigned DATA_W = strm_rx_pkg::DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   input  logic              lin,
   output logic [DATA_W-1:0] dout,
   output logic              lout,
   output logic              pulse
);

   localparam logic [DATA_W-1:0] ZERO_W = '0;

   logic [DATA_W-1:0] word_q;
   logic              last_q;
   logic              pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= ZERO_W;
         last_q <= 1'b0;
      end else if (take) begin
         word_q <= din;
         last_q <= lin;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= take;
   end

   assign dout  = word_q;
   assign lout  = last_q;
   assign pulse = pulse_q;

   AST_CAP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (dout == $past(din) && lout == $past(lin))); // R4
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(dout) && $stable(lout))); // R5
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> pulse); // R6
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(take)); // R6

endmodule

// File: rtl/strm_rx_gate.sv
module strm_rx_gate #(
   parameter int unsigned             DATA_W   = strm_rx_pkg::DEF_DATA_W,
   parameter strm_rx_pkg::rdy_mode_e  RDY_MODE = strm_rx_pkg::RDY_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_tvalid,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tlast,
   output logic              s_tready,
   input  logic              usr_ready,
   output logic [DATA_W-1:0] usr_data,
   output logic              usr_last,
   output logic              usr_done
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("strm_rx_gate: DATA_W must be at least 1");
      end
   endgenerate

   logic beat_take;

   strm_rx_rdy #(.RDY_MODE(RDY_MODE)) u_rdy (
      .clk       (clk),
      .rst_n     (rst_n),
      .usr_ready (usr_ready),
      .s_tready  (s_tready)
   );

   assign beat_take = s_tvalid & s_tready;

   strm_rx_cap #(.DATA_W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (beat_take),
      .din   (s_tdata),
      .lin   (s_tlast),
      .dout  (usr_data),
      .lout  (usr_last),
      .pulse (usr_done)
   );

   AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !s_tready |=> !usr_done); // R3
   AST_DONE_OUT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!usr_done && !usr_last && usr_data == '0)); // R1

endmodule

// File: tb/strm_rx_gate_test.sv
`timescale 1ns/1ps
module strm_rx_gate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_tvalid = 1'b0;
   logic [31:0] s_tdata = '0;
   logic        s_tlast = 1'b0;
   logic        usr_ready = 1'b0;
   logic        s_tready;
   logic [31:0] usr_data;
   logic        usr_last;
   logic        usr_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   strm_rx_gate uut (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tdata(s_tdata),
      .s_tlast(s_tlast), .s_tready(s_tready), .usr_ready(usr_ready),
      .usr_data(usr_data), .usr_last(usr_last), .usr_done(usr_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      usr_ready = 1'b1; s_tvalid = 1'b1; s_tdata = 32'h1234_5678; s_tlast = 1'b1;
      repeat (3) step();
      chk("R1 tready in reset", {31'd0, s_tready}, 32'd0);
      chk("R1 done in reset",   {31'd0, usr_done}, 32'd0);
      chk("R1 last in reset",   {31'd0, usr_last}, 32'd0);
      chk("R1 data in reset",   usr_data, 32'd0);
      usr_ready = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; rst_n = 1'b1;
      step();
   endtask

   task automatic t_ready_follow();
      usr_ready = 1'b1;
      chk("R2 tready not yet up", {31'd0, s_tready}, 32'd0);
      step();
      chk("R2 tready up after one edge", {31'd0, s_tready}, 32'd1);
      usr_ready = 1'b0;
      chk("R2 tready still up", {31'd0, s_tready}, 32'd1);
      step();
      chk("R2 tready down after one edge", {31'd0, s_tready}, 32'd0);
   endtask

   task automatic t_single_beat();
      usr_ready = 1'b1; step();
      s_tvalid = 1'b1; s_tdata = 32'hAAAA_BBBB; s_tlast = 1'b1;
      step();
      chk("R4 data after accept", usr_data, 32'hAAAA_BBBB);
      chk("R6 done pulse high",   {31'd0, usr_done}, 32'd1);
      chk("R7 last flag set",     {31'd0, usr_last}, 32'd1);
      s_tvalid = 1'b0;
      step();
      chk("R6 done pulse one cycle", {31'd0, usr_done}, 32'd0);
      chk("R5 data held",            usr_data, 32'hAAAA_BBBB);
   endtask

   task automatic t_blocked();
      usr_ready = 1'b0; step();
      chk("R3 tready low", {31'd0, s_tready}, 32'd0);
      s_tvalid = 1'b1; s_tdata = 32'hDEAD_0001; s_tlast = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R3 no done while blocked", {31'd0, usr_done}, 32'd0);
         chk("R3 data kept while blocked", usr_data, 32'hAAAA_BBBB);
      end
      s_tvalid = 1'b0;
   endtask

   task automatic t_back_to_back();
      usr_ready = 1'b1; step();
      s_tvalid = 1'b1; s_tdata = 32'hCCCC_0000; s_tlast = 1'b0;
      step();
      chk("R7 beat without last accepted", usr_data, 32'hCCCC_0000);
      chk("R7 last flag clear", {31'd0, usr_last}, 32'd0);
      chk("R6 done first beat", {31'd0, usr_done}, 32'd1);
      s_tdata = 32'hDDDD_1111; s_tlast = 1'b1;
      step();
      chk("R6 done second beat", {31'd0, usr_done}, 32'd1);
      chk("R4 second word", usr_data, 32'hDDDD_1111);
      chk("R7 second last flag", {31'd0, usr_last}, 32'd1);
      s_tvalid = 1'b0;
      step();
      chk("R6 done drops", {31'd0, usr_done}, 32'd0);
   endtask

   task automatic t_hold();
      s_tdata = 32'hEEEE_2222; s_tlast = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R5 data held idle", usr_data, 32'hDDDD_1111);
         chk("R5 last held idle", {31'd0, usr_last}, 32'd1);
         s_tdata = s_tdata + 32'd1;
      end
   endtask

   task automatic t_ready_drop();
      usr_ready = 1'b0; s_tvalid = 1'b1; s_tdata = 32'hF0F0_3333; s_tlast = 1'b0;
      step();
      chk("R8 in-flight beat accepted", usr_data, 32'hF0F0_3333);
      chk("R8 done for in-flight beat", {31'd0, usr_done}, 32'd1);
      chk("R8 tready now low", {31'd0, s_tready}, 32'd0);
      s_tdata = 32'h0F0F_4444; s_tlast = 1'b1;
      step();
      chk("R8 no further done", {31'd0, usr_done}, 32'd0);
      chk("R8 no further word", usr_data, 32'hF0F0_3333);
      s_tvalid = 1'b0;
   endtask

   initial begin
      t_reset();
      t_ready_follow();
      t_single_beat();
      t_blocked();
      t_back_to_back();
      t_hold();
      t_ready_drop();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule